// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry and exception return for a small 32-bit processor. When the pipeline raises a request with a 3-bit cause code and the program counter of the faulting instruction, the controller sorts the cause into a debug class or an ordinary class. It saves the program counter to the matching link register through a write strobe, saves the global interrupt enable into the matching saved-enable bit, and clears the global enable. One clock later it presents the handler address as the new fetch target.

The controller holds two handler base registers: an ordinary base and a debug base. It also holds the interrupt-enable register with its two saved copies, and a remap bit. The remap bit moves ordinary handlers onto the debug base. Software updates these registers through a simple select/write port, and the selected register is always visible on a read port. Two return operations reload the global enable from a saved copy and redirect fetch to the address held in the matching link register, which the register file supplies. Instruction decode, the register file and the pipeline flush are not part of this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted, and until the first event after reset, the global enable, both saved-enable bits, the remap bit and both base registers are zero. `redirect_valid` is 1 with `redirect_pc` zero (ordinary base, slot 0), and `link_we` is 0.
- R2: Causes 1 (breakpoint) and 3 (watchpoint) form the debug class. Causes 0 (reset), 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call) form the ordinary class.
- R3: One clock after an ordinary-class request, `link_we` is 1, `link_sel` is 0 (exception-address link register) and `link_data` equals the requested PC. The ordinary saved-enable bit becomes 1 if the global enable was 1 and otherwise keeps its value. The global enable becomes 0.
- R4: One clock after a debug-class request, `link_we` is 1, `link_sel` is 1 (breakpoint-address link register) and `link_data` equals the requested PC. The debug saved-enable bit becomes 1 if the global enable was 1 and otherwise keeps its value. The global enable becomes 0.
- R5: One clock after a request, `redirect_valid` is 1 and `redirect_pc` equals the selected base plus 32 times the cause.
- R6: Ordinary-class requests use the ordinary base when the remap bit is 0, and the debug base when it is 1.
- R7: Debug-class requests always use the debug base, whatever the remap bit holds.
- R8: Each base register stores bits [31:8] of the written word. Bits [7:0] always read as zero.
- R9: One clock after `eret`, the global enable equals the ordinary saved-enable bit and the controller redirects to `ea_in`. One clock after `bret`, the global enable equals the debug saved-enable bit and it redirects to `ba_in`. Neither return writes a link register. When both are raised, `eret` wins.
- R10: An exception request takes precedence over both returns, and a return takes precedence over a register write. The register write raised in the same cycle has no effect.
- R11: The write port selects with `csr_sel` as follows. 0 is the ordinary base, 1 is the debug base, 2 is the enable register (bit 0 global enable, bit 1 ordinary saved-enable, bit 2 debug saved-enable), and 3 is the debug-control register (bit 0 remap). `csr_rdata` shows the selected register with unused bits zero.
- R12: One clock after a cycle with no request and no return, `redirect_valid` and `link_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req | input | 1 | Exception request |
| exc_cause | input | 3 | Cause code of the request |
| cur_pc | input | 32 | PC of the instruction taking the exception |
| eret | input | 1 | Return from an ordinary exception |
| bret | input | 1 | Return from a debug exception |
| ea_in | input | 32 | Current exception-address link register value |
| ba_in | input | 32 | Current breakpoint-address link register value |
| csr_we | input | 1 | Control register write strobe |
| csr_sel | input | 2 | Control register select |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Selected control register value |
| link_we | output | 1 | Link register write strobe |
| link_sel | output | 1 | Link register select: 0 exception address, 1 breakpoint address |
| link_data | output | 32 | Value to write into the link register |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
The hardest situations to reach are those where events collide in one cycle. These are a request together with a register write, a return together with a write, and both returns together. The saved-enable case where the global enable is already clear, so the saved bit must keep a stale 1, is also hard to reach. The bench first builds these states on purpose. It sets the remap bit, enables interrupts, raises a request and then raises a second request without returning. It then runs a long pseudo-random phase in which requests, returns and writes overlap often. A behavioural model checks every output on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_EXC  = 3'd1,
    EV_ERET = 3'd2,
    EV_BRET = 3'd3,
    EV_CSR  = 3'd4
  } exc_event_e;

  typedef enum logic [1:0] {
    CSR_EBASE = 2'd0,
    CSR_DBASE = 2'd1,
    CSR_IEN   = 2'd2,
    CSR_DCTL  = 2'd3
  } csr_sel_e;

  localparam logic LINK_EA = 1'b0;
  localparam logic LINK_BA = 1'b1;

endpackage

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int XLEN       = 32,
  parameter int BASE_LSB   = 8,
  parameter int SLOT_SHIFT = 5,
  parameter int CAUSE_W    = 3,
  parameter logic [(1<<CAUSE_W)-1:0] DEBUG_MASK = 8'b0000_1010
) (
  input  logic [XLEN-BASE_LSB-1:0] ebase_hi,
  input  logic [XLEN-BASE_LSB-1:0] dbase_hi,
  input  logic                     remap,
  input  logic [CAUSE_W-1:0]       cause,
  output logic                     is_debug,
  output logic [XLEN-1:0]          vector
);
  localparam int BASE_W  = XLEN - BASE_LSB;
  localparam int NCAUSE  = 1 << CAUSE_W;

  logic [NCAUSE-1:0] cause_hot;
  logic [BASE_W-1:0] base_sel;

  // One-hot decode of the cause, then masked by the debug-class set.
  genvar gi;
  generate
    for (gi = 0; gi < NCAUSE; gi++) begin : g_dec
      assign cause_hot[gi] = (cause == CAUSE_W'(gi));
    end
  endgenerate

  always_comb begin
    is_debug = |(cause_hot & DEBUG_MASK);
    base_sel = (is_debug || remap) ? dbase_hi : ebase_hi;
    // Base low bits are zero, so concatenation equals base + cause*slot.
    vector   = {base_sel, cause, {SLOT_SHIFT{1'b0}}};
  end

endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BASE_LSB = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  exc_event_e               ev,
  input  logic                     ev_debug,
  input  logic [1:0]               csr_sel,
  input  logic [XLEN-1:0]          csr_wdata,
  output logic [XLEN-BASE_LSB-1:0] ebase_hi,
  output logic [XLEN-BASE_LSB-1:0] dbase_hi,
  output logic                     ie,
  output logic                     eie,
  output logic                     bie,
  output logic                     remap,
  output logic [XLEN-1:0]          csr_rdata
);
  localparam int BASE_W = XLEN - BASE_LSB;

  logic [BASE_W-1:0] ebase_q, ebase_d, dbase_q, dbase_d;
  logic              ie_q, ie_d, eie_q, eie_d, bie_q, bie_d, re_q, re_d;
  logic              ebase_en, dbase_en, ien_en, re_en;
  logic              unused_wbits;

  assign unused_wbits = ^csr_wdata[BASE_LSB-1:3];

  // Next-state
  always_comb begin
    ebase_d = csr_wdata[XLEN-1:BASE_LSB];
    dbase_d = csr_wdata[XLEN-1:BASE_LSB];
    re_d    = csr_wdata[0];
    ie_d    = ie_q;
    eie_d   = eie_q;
    bie_d   = bie_q;
    ebase_en = 1'b0;
    dbase_en = 1'b0;
    ien_en   = 1'b0;
    re_en    = 1'b0;
    case (ev)
      EV_EXC: begin
        ien_en = 1'b1;
        if (ev_debug) bie_d = bie_q | ie_q;
        else          eie_d = eie_q | ie_q;
        ie_d = 1'b0;
      end
      EV_ERET: begin
        ien_en = 1'b1;
        ie_d   = eie_q;
      end
      EV_BRET: begin
        ien_en = 1'b1;
        ie_d   = bie_q;
      end
      EV_CSR: begin
        case (csr_sel_e'(csr_sel))
          CSR_EBASE: ebase_en = 1'b1;
          CSR_DBASE: dbase_en = 1'b1;
          CSR_IEN: begin
            ien_en = 1'b1;
            ie_d   = csr_wdata[0];
            eie_d  = csr_wdata[1];
            bie_d  = csr_wdata[2];
          end
          default: re_en = 1'b1;
        endcase
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ebase_q <= '0;
      dbase_q <= '0;
      ie_q    <= 1'b0;
      eie_q   <= 1'b0;
      bie_q   <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      if (ebase_en) ebase_q <= ebase_d;
      if (dbase_en) dbase_q <= dbase_d;
      if (ien_en) begin
        ie_q  <= ie_d;
        eie_q <= eie_d;
        bie_q <= bie_d;
      end
      if (re_en) re_q <= re_d;
    end
  end

  // Read mux
  always_comb begin
    case (csr_sel_e'(csr_sel))
      CSR_EBASE: csr_rdata = {ebase_q, {BASE_LSB{1'b0}}};
      CSR_DBASE: csr_rdata = {dbase_q, {BASE_LSB{1'b0}}};
      CSR_IEN:   csr_rdata = {{(XLEN-3){1'b0}}, bie_q, eie_q, ie_q};
      default:   csr_rdata = {{(XLEN-1){1'b0}}, re_q};
    endcase
  end

  assign ebase_hi = ebase_q;
  assign dbase_hi = dbase_q;
  assign ie       = ie_q;
  assign eie      = eie_q;
  assign bie      = bie_q;
  assign remap    = re_q;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int BASE_LSB   = 8,
  parameter int SLOT_SHIFT = 5,
  parameter int CAUSE_W    = 3,
  parameter logic [(1<<CAUSE_W)-1:0] DEBUG_MASK = 8'b0000_1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               eret,
  input  logic               bret,
  input  logic [XLEN-1:0]    ea_in,
  input  logic [XLEN-1:0]    ba_in,
  input  logic               csr_we,
  input  logic [1:0]         csr_sel,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               link_we,
  output logic               link_sel,
  output logic [XLEN-1:0]    link_data,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc
);
  localparam int BASE_W = XLEN - BASE_LSB;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Event arbitration: request, then eret, then bret, then register write
  exc_event_e ev;
  always_comb begin
    if (exc_req)     ev = EV_EXC;
    else if (eret)   ev = EV_ERET;
    else if (bret)   ev = EV_BRET;
    else if (csr_we) ev = EV_CSR;
    else             ev = EV_NONE;
  end

  logic [BASE_W-1:0] ebase_w, dbase_w;
  logic              ie_w, eie_w, bie_w, re_w;
  logic              is_dbg;
  logic [XLEN-1:0]   vec_pc;

  exc_vector_gen #(
    .XLEN(XLEN), .BASE_LSB(BASE_LSB), .SLOT_SHIFT(SLOT_SHIFT),
    .CAUSE_W(CAUSE_W), .DEBUG_MASK(DEBUG_MASK)
  ) u_vec (
    .ebase_hi (ebase_w),
    .dbase_hi (dbase_w),
    .remap    (re_w),
    .cause    (exc_cause),
    .is_debug (is_dbg),
    .vector   (vec_pc)
  );

  exc_csr_bank #(.XLEN(XLEN), .BASE_LSB(BASE_LSB)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (ev),
    .ev_debug  (is_dbg),
    .csr_sel   (csr_sel),
    .csr_wdata (csr_wdata),
    .ebase_hi  (ebase_w),
    .dbase_hi  (dbase_w),
    .ie        (ie_w),
    .eie       (eie_w),
    .bie       (bie_w),
    .remap     (re_w),
    .csr_rdata (csr_rdata)
  );

  // Output next-state
  logic            rv_d, lwe_d, lsel_d;
  logic [XLEN-1:0] rpc_d, ldata_d;

  always_comb begin
    rv_d    = 1'b0;
    lwe_d   = 1'b0;
    lsel_d  = LINK_EA;
    rpc_d   = vec_pc;
    ldata_d = cur_pc;
    case (ev)
      EV_EXC: begin
        rv_d   = 1'b1;
        lwe_d  = 1'b1;
        lsel_d = is_dbg ? LINK_BA : LINK_EA;
      end
      EV_ERET: begin
        rv_d  = 1'b1;
        rpc_d = ea_in;
      end
      EV_BRET: begin
        rv_d  = 1'b1;
        rpc_d = ba_in;
      end
      default: ;
    endcase
  end

  // Output registers
  logic            rv_q, lwe_q, lsel_q;
  logic [XLEN-1:0] rpc_q, ldata_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rv_q    <= 1'b1;
      rpc_q   <= '0;
      lwe_q   <= 1'b0;
      lsel_q  <= LINK_EA;
      ldata_q <= '0;
    end else begin
      rv_q  <= rv_d;
      lwe_q <= lwe_d;
      if (rv_d) rpc_q <= rpc_d;
      if (lwe_d) begin
        lsel_q  <= lsel_d;
        ldata_q <= ldata_d;
      end
    end
  end

  assign redirect_valid = rv_q;
  assign redirect_pc    = rpc_q;
  assign link_we        = lwe_q;
  assign link_sel       = lsel_q;
  assign link_data      = ldata_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN     = 32,
  parameter int BASE_LSB = 8,
  parameter int CAUSE_W  = 3
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     exc_req,
  input logic [CAUSE_W-1:0]       exc_cause,
  input logic [XLEN-1:0]          cur_pc,
  input logic                     eret,
  input logic                     bret,
  input logic [XLEN-1:0]          ea_in,
  input logic                     link_we,
  input logic                     link_sel,
  input logic [XLEN-1:0]          link_data,
  input logic                     redirect_valid,
  input logic [XLEN-1:0]          redirect_pc,
  input logic                     ie_w,
  input logic                     eie_w,
  input logic                     bie_w,
  input logic                     re_w,
  input logic [XLEN-BASE_LSB-1:0] ebase_w,
  input logic [XLEN-BASE_LSB-1:0] dbase_w
);
  logic dbg_cause;
  assign dbg_cause = (exc_cause == CAUSE_W'(1)) || (exc_cause == CAUSE_W'(3));

  // R3
  nd_link_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req && !dbg_cause |=> link_we && !link_sel && link_data == $past(cur_pc)
      && eie_w == ($past(eie_w) | $past(ie_w)));

  // R4
  dbg_link_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req && dbg_cause |=> link_we && link_sel && link_data == $past(cur_pc)
      && bie_w == ($past(bie_w) | $past(ie_w)));

  // R3
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req |=> !ie_w && redirect_valid);

  // R5
  slot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req |=> redirect_pc[BASE_LSB-1:0] == {$past(exc_cause), 5'b0});

  // R7
  dbg_base_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req && dbg_cause |=> redirect_pc[XLEN-1:BASE_LSB] == $past(dbase_w));

  // R6
  nd_base_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req && !dbg_cause |=> redirect_pc[XLEN-1:BASE_LSB] ==
      ($past(re_w) ? $past(dbase_w) : $past(ebase_w)));

  // R9
  eret_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eret && !exc_req |=> ie_w == $past(eie_w) && redirect_pc == $past(ea_in) && !link_we);

  // R10
  csr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_req || eret || bret |=> $stable(ebase_w) && $stable(dbase_w) && $stable(re_w));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exc_req && !eret && !bret |=> !redirect_valid && !link_we);

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .BASE_LSB(BASE_LSB), .CAUSE_W(CAUSE_W)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .exc_req        (exc_req),
  .exc_cause      (exc_cause),
  .cur_pc         (cur_pc),
  .eret           (eret),
  .bret           (bret),
  .ea_in          (ea_in),
  .link_we        (link_we),
  .link_sel       (link_sel),
  .link_data      (link_data),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .ie_w           (ie_w),
  .eie_w          (eie_w),
  .bie_w          (bie_w),
  .re_w           (re_w),
  .ebase_w        (ebase_w),
  .dbase_w        (dbase_w)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, eret, bret, csr_we;
  logic [2:0]  exc_cause;
  logic [31:0] cur_pc, ea_in, ba_in, csr_wdata;
  logic [1:0]  csr_sel;
  logic [31:0] csr_rdata, link_data, redirect_pc;
  logic        link_we, link_sel, redirect_valid;

  int checks = 0;
  int failures = 0;

  // Behavioural model state
  logic [31:0] m_eba, m_deba;
  logic        m_ie, m_eie, m_bie, m_re;
  logic        e_rv, e_lwe, e_lsel;
  logic [31:0] e_rpc, e_ldata;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
    .cur_pc(cur_pc), .eret(eret), .bret(bret), .ea_in(ea_in), .ba_in(ba_in),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .link_we(link_we), .link_sel(link_sel),
    .link_data(link_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [31:0] model_rdata(input logic [1:0] sel);
    case (sel)
      2'd0:    return m_eba;
      2'd1:    return m_deba;
      2'd2:    return {29'b0, m_bie, m_eie, m_ie};
      default: return {31'b0, m_re};
    endcase
  endfunction

  task automatic model_update();
    logic dbg;
    e_rv  = 1'b0;
    e_lwe = 1'b0;
    if (exc_req) begin
      dbg     = (exc_cause == 3'd1) || (exc_cause == 3'd3);
      e_rpc   = ((dbg || m_re) ? m_deba : m_eba) + 32'(exc_cause) * 32;
      e_rv    = 1'b1;
      e_lwe   = 1'b1;
      e_lsel  = dbg;
      e_ldata = cur_pc;
      if (dbg) m_bie = m_bie | m_ie;
      else     m_eie = m_eie | m_ie;
      m_ie = 1'b0;
    end else if (eret) begin
      m_ie = m_eie; e_rv = 1'b1; e_rpc = ea_in;
    end else if (bret) begin
      m_ie = m_bie; e_rv = 1'b1; e_rpc = ba_in;
    end else if (csr_we) begin
      case (csr_sel)
        2'd0: m_eba  = csr_wdata & 32'hFFFF_FF00;
        2'd1: m_deba = csr_wdata & 32'hFFFF_FF00;
        2'd2: begin m_ie = csr_wdata[0]; m_eie = csr_wdata[1]; m_bie = csr_wdata[2]; end
        default: m_re = csr_wdata[0];
      endcase
    end
  endtask

  // One clock: model update at the edge, compare at the following falling edge
  task automatic tick(input string req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(req, "redirect_valid", 32'(redirect_valid), 32'(e_rv));
    check(req, "link_we", 32'(link_we), 32'(e_lwe));
    if (e_rv)  check(req, "redirect_pc", redirect_pc, e_rpc);
    if (e_lwe) begin
      check(req, "link_sel", 32'(link_sel), 32'(e_lsel));
      check(req, "link_data", link_data, e_ldata);
    end
    check(req, "csr_rdata", csr_rdata, model_rdata(csr_sel));
  endtask

  task automatic idle_in();
    exc_req = 0; eret = 0; bret = 0; csr_we = 0;
  endtask

  task automatic do_csr(input string req, input logic [1:0] sel, input logic [31:0] d);
    idle_in(); csr_we = 1; csr_sel = sel; csr_wdata = d;
    tick(req);
  endtask

  task automatic do_exc(input string req, input logic [2:0] c, input logic [31:0] pc,
                        input logic [1:0] sel);
    idle_in(); exc_req = 1; exc_cause = c; cur_pc = pc; csr_sel = sel;
    tick(req);
  endtask

  task automatic do_idle(input string req, input logic [1:0] sel);
    idle_in(); csr_sel = sel;
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    idle_in();
    exc_cause = 0; cur_pc = 0; ea_in = 0; ba_in = 0; csr_sel = 0; csr_wdata = 0;
    m_eba = 0; m_deba = 0; m_ie = 0; m_eie = 0; m_bie = 0; m_re = 0;
    e_rv = 0; e_lwe = 0; e_lsel = 0; e_rpc = 0; e_ldata = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "redirect_valid", 32'(redirect_valid), 32'd1);
    check("R1", "redirect_pc", redirect_pc, 32'd0);
    check("R1", "link_we", 32'(link_we), 32'd0);
    for (int s = 0; s < 4; s++) begin
      csr_sel = 2'(s);
      #1 check("R1", "csr_rdata", csr_rdata, 32'd0);
    end
    csr_sel = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1", "redirect_valid sync", 32'(redirect_valid), 32'd1);
    do_idle("R12", 2'd2);

    // R8 / R11: base and control writes
    do_csr("R8", 2'd0, 32'h1234_56FF);
    do_csr("R8", 2'd1, 32'hABCD_0011);
    do_idle("R11", 2'd0);
    do_idle("R11", 2'd1);
    do_csr("R11", 2'd2, 32'h0000_0001);

    // R3 / R5 / R6: interrupt from ordinary base
    do_exc("R3", 3'd6, 32'h0000_0100, 2'd2);
    do_idle("R12", 2'd2);
    // R9: eret restores enable
    idle_in(); eret = 1; ea_in = 32'h0000_0104; csr_sel = 2'd2; tick("R9");
    // R4 / R7: breakpoint from debug base
    do_exc("R4", 3'd1, 32'h0000_0200, 2'd2);
    idle_in(); bret = 1; ba_in = 32'h0000_0204; csr_sel = 2'd2; tick("R9");
    // R6: remap ordinary onto debug base
    do_csr("R6", 2'd3, 32'h0000_0001);
    do_exc("R6", 3'd2, 32'h0000_0300, 2'd3);
    // R3: second request with enable already clear keeps saved bits
    do_exc("R3", 3'd5, 32'h0000_0304, 2'd2);
    do_csr("R7", 2'd3, 32'h0000_0000);
    do_exc("R7", 3'd3, 32'h0000_0308, 2'd2);
    // R10: collisions
    idle_in(); exc_req = 1; exc_cause = 3'd7; cur_pc = 32'h400; csr_we = 1;
    csr_sel = 2'd0; csr_wdata = 32'hFFFF_FFFF; tick("R10");
    idle_in(); eret = 1; bret = 1; ea_in = 32'h500; ba_in = 32'h600; csr_sel = 2'd2; tick("R9");
    idle_in(); bret = 1; csr_we = 1; ba_in = 32'h700; csr_sel = 2'd3;
    csr_wdata = 32'h1; tick("R10");
    idle_in(); eret = 1; exc_req = 1; exc_cause = 3'd4; cur_pc = 32'h800; csr_sel = 2'd2; tick("R10");

    // R2: every cause with enable set beforehand, both remap settings
    for (int r = 0; r < 2; r++) begin
      do_csr("R2", 2'd3, 32'(r));
      for (int c = 0; c < 8; c++) begin
        do_csr("R2", 2'd2, 32'h1);
        do_exc("R2", 3'(c), 32'h1000 + 32'(c) * 4, 2'd2);
        do_idle("R12", 2'(c));
      end
    end

    // R10: pseudo-random overlap of all operations
    for (int i = 0; i < 2000; i++) begin
      exc_req   = ($urandom % 4) == 0;
      eret      = ($urandom % 6) == 0;
      bret      = ($urandom % 6) == 0;
      csr_we    = ($urandom % 2) == 0;
      exc_cause = 3'($urandom);
      cur_pc    = $urandom;
      ea_in     = $urandom;
      ba_in     = $urandom;
      csr_sel   = 2'($urandom);
      csr_wdata = $urandom;
      tick("R10");
    end

    finish_run();
  end

endmodule